// File: doc/BRIEF.md
# Streaming Horner Polynomial Evaluator

This block evaluates a polynomial of any degree at a point `x` using Horner's recurrence. Coefficients are streamed in one per clock on a 32-bit input, qualified by a valid strobe. The highest-degree coefficient comes first and the constant term comes last. A first flag marks the opening coefficient of an evaluation, and a last flag marks the constant term. The point `x` is captured together with the first coefficient. One cycle after the constant term has been taken in, the block raises `done` for a single cycle and presents the value on `result`. That value stays on `result` until the next evaluation begins.

The datapath has a single 32-bit multiplier, a single 32-bit adder and an accumulator register. On each accepted coefficient `c` the accumulator becomes `c + x·acc`, so the critical path is one multiply followed by one add. On the first coefficient the accumulator simply loads `c`, as though the previous value were zero. All arithmetic wraps modulo 2^32.

A small controller has two states. `ST_IDLE` waits for a coefficient flagged first. `ST_RUN` absorbs coefficients until one is flagged last. The transitions are:

- START: `ST_IDLE` → `ST_RUN`, on a valid coefficient that is flagged first but not last.
- FINISH: `ST_RUN` → `ST_IDLE`, on a valid coefficient flagged last.
- SINGLE: `ST_IDLE` → `ST_IDLE` with `done`, on a coefficient flagged both first and last (a constant polynomial).
- RESTART: `ST_RUN` → `ST_RUN`, on a coefficient flagged first but not last, which discards the partial result.
- STALL: remain in the current state while `coef_valid` is low.

Top module: `horner_eval`

## Requirements
- R1: After reset `done` is 0 and `result` is 0.
- R2: A valid coefficient with `coef_first`=1 loads the accumulator with that coefficient, whatever the accumulator held before.
- R3: Each further valid coefficient `c` in an evaluation updates the accumulator to `c + x·acc`, so feeding a_n … a_0 yields a0 + a1·x + … + an·x^n.
- R4: `x_in` is captured only with the first coefficient; changes to `x_in` later in the evaluation do not alter the result.
- R5: `done` is 1 in exactly the one cycle after the coefficient flagged last is accepted, and `result` then holds the polynomial value. `result` keeps that value until the next first coefficient.
- R6: Cycles with `coef_valid`=0 leave the accumulator and the latched x unchanged, whatever `coef_in` carries.
- R7: In `ST_IDLE`, valid coefficients without `coef_first` are ignored: `done` stays 0 and `result` is unchanged.
- R8: A coefficient flagged first during `ST_RUN` restarts the evaluation; earlier coefficients do not contribute.
- R9: A coefficient flagged both first and last is a degree-0 evaluation: `done` follows one cycle later with `result` equal to that coefficient.
- R10: Products and sums keep only their low 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_in | input | 32 | Evaluation point, sampled with the first coefficient |
| coef_in | input | 32 | Coefficient, highest degree first |
| coef_valid | input | 1 | Coefficient strobe |
| coef_first | input | 1 | Marks the highest-degree coefficient |
| coef_last | input | 1 | Marks the constant term |
| result | output | 32 | Accumulator value; the polynomial value once `done` has risen |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
Each coefficient is taken in at the clock edge after it is driven, so the accumulator reflects it one cycle later. `done` and the final value appear one cycle after the constant term is driven. The bench drives inputs on the falling edge and checks `done` and `result` on the falling edge that follows the last coefficient. On the falling edge after that, it checks that `done` has dropped and that `result` has held. Degrees 0 to 5 are swept against several evaluation points, including points that force wrap-around. These runs are combined with idle bubbles, mid-run changes to `x_in`, restarts and ignored idle traffic. Expected values come from a wrapped Horner loop in the bench.

// File: rtl/horner_pkg.sv
package horner_pkg;
    localparam int DATA_W = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } hstate_t;
endpackage

// File: rtl/horner_ctrl.sv
module horner_ctrl
    import horner_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic coef_valid,
    input  logic coef_first,
    input  logic coef_last,
    output logic start,
    output logic accept,
    output logic done
);
    hstate_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (coef_valid && coef_first) begin
                    start  = 1'b1;
                    accept = 1'b1;
                    state_d = coef_last ? ST_IDLE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (coef_valid) begin
                    start  = coef_first;
                    accept = 1'b1;
                    if (coef_last) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= accept && coef_last;
    end

    // R5
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(coef_valid && coef_last));

    // R7
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && coef_valid && !coef_first) |=> (state_q == ST_IDLE && !done));

    // R9
    single_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_valid && coef_first && coef_last) |=> (done && state_q == ST_IDLE));
endmodule

// File: rtl/horner_datapath.sv
module horner_datapath
    import horner_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         accept,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] coef_in,
    output logic [W-1:0] acc
);
    logic [W-1:0] x_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] prod;
    logic [W-1:0] sum;

    assign prod = x_q * acc_q;
    assign sum  = coef_in + prod;
    assign acc  = acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q   <= '0;
            acc_q <= '0;
        end else if (start) begin
            x_q   <= x_in;
            acc_q <= coef_in;
        end else if (accept) begin
            acc_q <= sum;
        end
    end

    // R2
    first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> acc_q == $past(coef_in));

    // R4
    x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(x_q));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(acc_q));
endmodule

// File: rtl/horner_eval.sv
module horner_eval
    import horner_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] coef_in,
    input  logic              coef_valid,
    input  logic              coef_first,
    input  logic              coef_last,
    output logic [DATA_W-1:0] result,
    output logic              done
);
    logic start;
    logic accept;

    horner_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .coef_valid (coef_valid),
        .coef_first (coef_first),
        .coef_last  (coef_last),
        .start      (start),
        .accept     (accept),
        .done       (done)
    );

    horner_datapath #(.W(DATA_W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .accept  (accept),
        .x_in    (x_in),
        .coef_in (coef_in),
        .acc     (result)
    );

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done || $stable(result) || $past(coef_valid)));
endmodule

// File: tb/horner_eval_test.sv
module horner_eval_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] x_in = '0;
    logic [31:0] coef_in = '0;
    logic        coef_valid = 1'b0;
    logic        coef_first = 1'b0;
    logic        coef_last = 1'b0;
    logic [31:0] result;
    logic        done;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;
    logic [31:0] cf [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    horner_eval uut (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .coef_in(coef_in),
        .coef_valid(coef_valid), .coef_first(coef_first), .coef_last(coef_last),
        .result(result), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic idle_cycle();
        @(negedge clk);
        coef_valid = 1'b0; coef_first = 1'b0; coef_last = 1'b0;
        coef_in = 32'hDEAD_BEEF;
    endtask

    // Streams cf[deg] .. cf[0]; optional bubbles and x_in disturbance
    task automatic eval_poly(input int deg, input logic [31:0] xv, input bit bubble, input bit xwiggle);
        logic [31:0] expv = '0;
        for (int i = deg; i >= 0; i--) begin
            if (bubble && i != deg) begin
                @(negedge clk);
                coef_valid = 1'b0; coef_first = 1'b0; coef_last = 1'b0;
                coef_in = next_rand();
                x_in = ~xv;
            end
            @(negedge clk);
            coef_valid = 1'b1;
            coef_first = (i == deg);
            coef_last  = (i == 0);
            coef_in    = cf[i];
            x_in       = (i == deg) ? xv : (xwiggle ? (xv ^ 32'h5A5A_0001) : xv);
            expv       = cf[i] + xv * expv;
        end
        @(negedge clk);
        coef_valid = 1'b0; coef_first = 1'b0; coef_last = 1'b0;
        coef_in = 32'hFFFF_FFFF;
        chk(done === 1'b1, "R5 done", {31'b0, done}, 32'd1);
        chk(result === expv, deg == 0 ? "R9 result" : "R3 result", result, expv);
        @(negedge clk);
        chk(done === 1'b0, "R5 pulse", {31'b0, done}, 32'd0);
        chk(result === expv, "R5 hold", result, expv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] xs [0:4];
        logic [31:0] held;
        xs[0] = 32'd0; xs[1] = 32'd1; xs[2] = 32'hFFFF_FFFF;
        xs[3] = 32'd3; xs[4] = 32'h8001_0003;

        repeat (3) @(negedge clk);
        // R1
        chk(done === 1'b0, "R1 done", {31'b0, done}, 32'd0);
        chk(result === 32'd0, "R1 result", result, 32'd0);
        rst_n = 1'b1;
        idle_cycle();

        // R3 / R10 / R9 sweep over degree and point
        for (int d = 0; d <= 5; d++) begin
            for (int k = 0; k < 5; k++) begin
                for (int j = 0; j < 8; j++) cf[j] = next_rand();
                eval_poly(d, xs[k], 1'b0, 1'b0);
            end
        end

        // R10 wrap: 2^16 squared wraps to 0, plus all-ones coefficients
        cf[2] = 32'd1; cf[1] = 32'd0; cf[0] = 32'd7;
        eval_poly(2, 32'h0001_0000, 1'b0, 1'b0);
        cf[2] = 32'hFFFF_FFFF; cf[1] = 32'hFFFF_FFFF; cf[0] = 32'hFFFF_FFFF;
        eval_poly(2, 32'hFFFF_FFFF, 1'b0, 1'b0);

        // R6 bubbles with garbage on coef_in
        for (int d = 1; d <= 4; d++) begin
            for (int j = 0; j < 8; j++) cf[j] = next_rand();
            eval_poly(d, 32'd5 + d, 1'b1, 1'b0);
        end

        // R4 x_in disturbed after the first coefficient
        for (int d = 1; d <= 4; d++) begin
            for (int j = 0; j < 8; j++) cf[j] = next_rand();
            eval_poly(d, 32'h0000_0102 * d, 1'b1, 1'b1);
        end

        // R7 idle coefficients without first are ignored
        held = result;
        @(negedge clk);
        coef_valid = 1'b1; coef_first = 1'b0; coef_last = 1'b1; coef_in = 32'h1111_2222;
        @(negedge clk);
        chk(done === 1'b0, "R7 done", {31'b0, done}, 32'd0);
        chk(result === held, "R7 result", result, held);
        coef_last = 1'b0; coef_in = 32'h3333_4444;
        @(negedge clk);
        chk(result === held, "R7 result2", result, held);
        idle_cycle();

        // R8 restart mid-evaluation
        @(negedge clk);
        coef_valid = 1'b1; coef_first = 1'b1; coef_last = 1'b0; coef_in = 32'd99; x_in = 32'd7;
        @(negedge clk);
        coef_first = 1'b0; coef_in = 32'd55;
        for (int j = 0; j < 8; j++) cf[j] = next_rand();
        eval_poly(3, 32'd11, 1'b0, 1'b0);   // R8 expected from new stream only

        // R2 first coefficient loads regardless of previous accumulator
        cf[0] = 32'h0BAD_F00D;
        eval_poly(0, 32'd9, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule